// File: doc/BRIEF.md
# Picture-in-Picture Window Fetch Selector

This block sits in a display scan path between the scan position counter and the frame-buffer fetch logic. For each scan position (x, y) it decides whether the pixel comes from the main image or from a rectangular overlay window. It then produces the address of the 16-bit frame-buffer word that holds that pixel and the bit offset of the pixel inside that word.

The overlay has its own base address and its own line stride, so its image can sit in a memory region apart from the main image. Both images use one shared pixel depth of 1, 2, 4, 8, 12 or 16 bits per pixel. The configuration pins are copied into a shadow bank only on a frame-start pulse, so a window never moves part way through a frame.

Scan positions enter on a valid/ready stream and fetch requests leave on another valid/ready stream, with one output register between them. A position is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new position is taken.

Top module: `pip_fetch_sel`

## Requirements
- R1: When `rst` (synchronous, active high) has been sampled high, `out_valid` is low on the following cycle and `in_ready` is high.
- R2: A position selects the overlay (`out_sub` = 1) exactly when x0 <= x <= x1 and y0 <= y <= y1, with all four bounds inclusive.
- R3: Outside the overlay, `out_addr` = main_base + y * main_stride + word(x), where strides count 16-bit words and the result wraps to the address width.
- R4: Inside the overlay, `out_addr` = sub_base + (y - y0) * sub_stride + word(x - x0).
- R5: `cfg_bpp` codes 0, 1, 2, 3 and 5 select 1, 2, 4, 8 and 16 bpp, and codes 6 and 7 also act as 16 bpp. In these modes word(c) = (c * bpp) / 16 and `out_bit` = (c * bpp) mod 16, so pixel 0 of a word sits in its least significant bits.
- R6: `cfg_bpp` code 4 selects 12 bpp, stored one pixel per word. Here word(c) = c and `out_bit` = 0.
- R7: Changes on the configuration pins take effect only for positions accepted after a cycle in which `frame_start` was high. A position accepted in the same cycle as `frame_start` still uses the previous settings.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_sub` and `out_bit` hold their values on the next cycle.
- R9: Every accepted position produces exactly one output, one cycle after acceptance at the earliest, and outputs leave in the order the positions were accepted.
- R10: When x1 < x0 or y1 < y0, no position selects the overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Loads the configuration pins into the shadow bank |
| cfg_main_base | input | AW | Word address of the main image |
| cfg_main_stride | input | SW | Main line length in 16-bit words |
| cfg_sub_base | input | AW | Word address of the overlay image |
| cfg_sub_stride | input | SW | Overlay line length in 16-bit words |
| cfg_sub_x0 | input | XW | Overlay left column (inclusive) |
| cfg_sub_x1 | input | XW | Overlay right column (inclusive) |
| cfg_sub_y0 | input | YW | Overlay top line (inclusive) |
| cfg_sub_y1 | input | YW | Overlay bottom line (inclusive) |
| cfg_bpp | input | 3 | Pixel depth code |
| in_valid | input | 1 | Scan position valid |
| in_ready | output | 1 | Position can be accepted |
| in_x | input | XW | Scan column |
| in_y | input | YW | Scan line |
| out_valid | output | 1 | Fetch request valid |
| out_ready | input | 1 | Consumer takes the request |
| out_addr | output | AW | Fetch word address |
| out_sub | output | 1 | 1 = overlay, 0 = main image |
| out_bit | output | 4 | Bit offset of the pixel in the word |

## Verification
Two functions can fall in the same cycle: a shadow reload and the acceptance of a position. The bench provokes this by moving the overlay on the configuration pins and then raising `frame_start` on the same edge that accepts a position inside the old window, with `out_ready` held high. That position must still get the old overlay address. The next position at the same spot must get the main-image address. The output stall is also overlapped with acceptance, because random `out_ready` gaps hold results while new positions wait, and every held value is compared on each stalled cycle.

// File: rtl/pip_pkg.sv
package pip_pkg;

  typedef enum logic [2:0] {
    DEPTH_1  = 3'd0,
    DEPTH_2  = 3'd1,
    DEPTH_4  = 3'd2,
    DEPTH_8  = 3'd3,
    DEPTH_12 = 3'd4,
    DEPTH_16 = 3'd5
  } depth_e;

  // log2 of pixels per 16-bit word; unpacked modes give 0
  function automatic logic [2:0] pack_shift(input depth_e d);
    case (d)
      DEPTH_1: pack_shift = 3'd4;
      DEPTH_2: pack_shift = 3'd3;
      DEPTH_4: pack_shift = 3'd2;
      DEPTH_8: pack_shift = 3'd1;
      default: pack_shift = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pip_shadow_bank.sv
module pip_shadow_bank
  import pip_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int AW = 24,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] c_main_base,
  input  logic [SW-1:0] c_main_stride,
  input  logic [AW-1:0] c_sub_base,
  input  logic [SW-1:0] c_sub_stride,
  input  logic [XW-1:0] c_x0,
  input  logic [XW-1:0] c_x1,
  input  logic [YW-1:0] c_y0,
  input  logic [YW-1:0] c_y1,
  input  logic [2:0]    c_depth,
  output logic [AW-1:0] s_main_base,
  output logic [SW-1:0] s_main_stride,
  output logic [AW-1:0] s_sub_base,
  output logic [SW-1:0] s_sub_stride,
  output logic [XW-1:0] s_x0,
  output logic [XW-1:0] s_x1,
  output logic [YW-1:0] s_y0,
  output logic [YW-1:0] s_y1,
  output depth_e        s_depth
);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_main_base   <= '0;
      s_main_stride <= '0;
      s_sub_base    <= '0;
      s_sub_stride  <= '0;
      s_x0          <= '0;
      s_x1          <= '0;
      s_y0          <= '0;
      s_y1          <= '0;
      s_depth       <= DEPTH_1;
    end else if (load) begin
      s_main_base   <= c_main_base;
      s_main_stride <= c_main_stride;
      s_sub_base    <= c_sub_base;
      s_sub_stride  <= c_sub_stride;
      s_x0          <= c_x0;
      s_x1          <= c_x1;
      s_y0          <= c_y0;
      s_y1          <= c_y1;
      s_depth       <= depth_e'(c_depth);
    end
  end

endmodule

// File: rtl/pip_hit_test.sv
module pip_hit_test #(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [XW-1:0] x0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y0,
  input  logic [YW-1:0] y1,
  output logic          hit,
  output logic [XW-1:0] rel_x,
  output logic [YW-1:0] rel_y
);

  logic in_cols, in_rows;

  always_comb begin
    in_cols = (x >= x0) && (x <= x1);
    in_rows = (y >= y0) && (y <= y1);
    hit     = in_cols && in_rows;
    rel_x   = x - x0;
    rel_y   = y - y0;
  end

endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen
  import pip_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int AW = 24,
  parameter int SW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  input  logic [YW-1:0] row,
  input  logic [XW-1:0] col,
  input  depth_e        depth,
  output logic [AW-1:0] addr,
  output logic [3:0]    bit_off
);

  logic [2:0]    sh;
  logic [3:0]    lane_mask;
  logic [3:0]    lane;
  logic [AW-1:0] line_off;
  logic [AW-1:0] word_off;

  always_comb begin
    sh        = pack_shift(depth);
    lane_mask = (4'd1 << sh) - 4'd1;
    lane      = col[3:0] & lane_mask;
    line_off  = AW'(row) * AW'(stride);
    word_off  = AW'(col >> sh);
    addr      = base + line_off + word_off;
    bit_off   = lane << (3'd4 - sh);
  end

endmodule

// File: rtl/pip_fetch_sel.sv
module pip_fetch_sel
  import pip_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int AW = 24,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [AW-1:0] cfg_main_base,
  input  logic [SW-1:0] cfg_main_stride,
  input  logic [AW-1:0] cfg_sub_base,
  input  logic [SW-1:0] cfg_sub_stride,
  input  logic [XW-1:0] cfg_sub_x0,
  input  logic [XW-1:0] cfg_sub_x1,
  input  logic [YW-1:0] cfg_sub_y0,
  input  logic [YW-1:0] cfg_sub_y1,
  input  logic [2:0]    cfg_bpp,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_sub,
  output logic [3:0]    out_bit
);

  localparam int NWIN = 2;
  localparam int WMAIN = 0;
  localparam int WSUB = 1;

  logic [AW-1:0] sh_main_base, sh_sub_base;
  logic [SW-1:0] sh_main_stride, sh_sub_stride;
  logic [XW-1:0] sh_x0, sh_x1;
  logic [YW-1:0] sh_y0, sh_y1;
  depth_e        sh_depth;

  pip_shadow_bank #(.XW(XW), .YW(YW), .AW(AW), .SW(SW)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_start),
    .c_main_base(cfg_main_base), .c_main_stride(cfg_main_stride),
    .c_sub_base(cfg_sub_base), .c_sub_stride(cfg_sub_stride),
    .c_x0(cfg_sub_x0), .c_x1(cfg_sub_x1), .c_y0(cfg_sub_y0), .c_y1(cfg_sub_y1),
    .c_depth(cfg_bpp),
    .s_main_base(sh_main_base), .s_main_stride(sh_main_stride),
    .s_sub_base(sh_sub_base), .s_sub_stride(sh_sub_stride),
    .s_x0(sh_x0), .s_x1(sh_x1), .s_y0(sh_y0), .s_y1(sh_y1),
    .s_depth(sh_depth)
  );

  logic          hit;
  logic [XW-1:0] sub_col;
  logic [YW-1:0] sub_row;

  pip_hit_test #(.XW(XW), .YW(YW)) u_hit (
    .x(in_x), .y(in_y), .x0(sh_x0), .x1(sh_x1), .y0(sh_y0), .y1(sh_y1),
    .hit(hit), .rel_x(sub_col), .rel_y(sub_row)
  );

  logic [AW-1:0] win_base   [NWIN];
  logic [SW-1:0] win_stride [NWIN];
  logic [YW-1:0] win_row    [NWIN];
  logic [XW-1:0] win_col    [NWIN];
  logic [AW-1:0] win_addr   [NWIN];
  logic [3:0]    win_bit    [NWIN];

  assign win_base[WMAIN]   = sh_main_base;
  assign win_stride[WMAIN] = sh_main_stride;
  assign win_row[WMAIN]    = in_y;
  assign win_col[WMAIN]    = in_x;
  assign win_base[WSUB]    = sh_sub_base;
  assign win_stride[WSUB]  = sh_sub_stride;
  assign win_row[WSUB]     = sub_row;
  assign win_col[WSUB]     = sub_col;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    pip_addr_gen #(.XW(XW), .YW(YW), .AW(AW), .SW(SW)) u_agen (
      .base(win_base[w]), .stride(win_stride[w]),
      .row(win_row[w]), .col(win_col[w]), .depth(sh_depth),
      .addr(win_addr[w]), .bit_off(win_bit[w])
    );
  end

  logic in_fire;
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_sub   <= 1'b0;
      out_bit   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_fire) begin
        out_sub  <= hit;
        out_addr <= hit ? win_addr[WSUB] : win_addr[WMAIN];
        out_bit  <= hit ? win_bit[WSUB] : win_bit[WMAIN];
      end
    end
  end

endmodule

// File: rtl/pip_fetch_sel_chk.sv
module pip_fetch_sel_chk #(
  parameter int XW = 10,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_sub,
  input logic [3:0]    out_bit,
  input logic [XW-1:0] cfg_x0,
  input logic [XW-1:0] sh_x0
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_STALL_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid); // R8

  AST_STALL_DATA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_addr) && $stable(out_sub) && $stable(out_bit))); // R8

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(sh_x0)); // R7

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (sh_x0 == $past(cfg_x0))); // R7

endmodule

bind pip_fetch_sel pip_fetch_sel_chk #(.XW(XW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_sub(out_sub), .out_bit(out_bit),
  .cfg_x0(cfg_sub_x0), .sh_x0(sh_x0)
);

// File: tb/sim_pip_fetch_sel.sv
`timescale 1ns/1ps
module sim_pip_fetch_sel;
  localparam int XW = 10;
  localparam int YW = 10;
  localparam int AW = 24;
  localparam int SW = 12;

  typedef struct {
    logic [AW-1:0] mb; logic [SW-1:0] ms;
    logic [AW-1:0] sb; logic [SW-1:0] ss;
    int x0, x1, y0, y1, code;
  } cfg_t;

  typedef struct {
    logic [AW-1:0] addr; logic sub; logic [3:0] bofs; string tag;
  } exp_t;

  logic clk = 0, rst = 1, frame_start = 0;
  logic in_valid = 0, out_ready = 1;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic in_ready, out_valid, out_sub;
  logic [AW-1:0] out_addr;
  logic [3:0] out_bit;

  cfg_t pend, act;
  exp_t sb_q[$];
  int checks = 0, fails = 0, pushed = 0, popped = 0;
  bit rand_rdy = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pip_fetch_sel #(.XW(XW), .YW(YW), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_main_base(pend.mb), .cfg_main_stride(pend.ms),
    .cfg_sub_base(pend.sb), .cfg_sub_stride(pend.ss),
    .cfg_sub_x0(XW'(pend.x0)), .cfg_sub_x1(XW'(pend.x1)),
    .cfg_sub_y0(YW'(pend.y0)), .cfg_sub_y1(YW'(pend.y1)),
    .cfg_bpp(3'(pend.code)),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_sub(out_sub), .out_bit(out_bit)
  );

  function automatic exp_t model(input int x, input int y, input string tag);
    exp_t e;
    int bpp, c, r, word;
    logic [AW-1:0] base; int stride;
    bit hit;
    case (act.code)
      0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; 4: bpp = 12;
      default: bpp = 16;
    endcase
    hit = (x >= act.x0) && (x <= act.x1) && (y >= act.y0) && (y <= act.y1);
    if (hit) begin c = x - act.x0; r = y - act.y0; base = act.sb; stride = int'(act.ss); end
    else begin c = x; r = y; base = act.mb; stride = int'(act.ms); end
    if (bpp == 12) begin word = c; e.bofs = 4'd0; end
    else begin word = (c * bpp) / 16; e.bofs = 4'((c * bpp) % 16); end
    e.addr = base + AW'(r * stride) + AW'(word);
    e.sub = hit;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", tag, msg); end
  endtask

  // driver: offers a position, pushes the expected result on acceptance
  task automatic send(input int x, input int y, input bit fs, input string tag);
    @(negedge clk);
    in_valid = 1; in_x = XW'(x); in_y = YW'(y); frame_start = fs;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb_q.push_back(model(x, y, tag));
    pushed++;
    if (fs) act = pend;
  endtask

  task automatic new_frame();
    @(negedge clk);
    in_valid = 0; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    act = pend;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 0; frame_start = 0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rand_rdy ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: pops and compares at each output handshake, checks holds on stalls
  bit stalled = 0;
  logic [AW-1:0] h_addr; logic h_sub; logic [3:0] h_bit;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (stalled)
        check(out_valid && out_addr == h_addr && out_sub == h_sub && out_bit == h_bit, "R8",
              $sformatf("held v=%0b a=%h s=%0b b=%0d exp v=1 a=%h s=%0b b=%0d",
                        out_valid, out_addr, out_sub, out_bit, h_addr, h_sub, h_bit));
      stalled = out_valid && !out_ready;
      h_addr = out_addr; h_sub = out_sub; h_bit = out_bit;
      if (out_valid && out_ready) begin
        popped++;
        if (sb_q.size() == 0) check(0, "R9", "output with no accepted position (act 1 exp 0)");
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(out_addr == e.addr && out_sub == e.sub && out_bit == e.bofs, e.tag,
                $sformatf("act a=%h s=%0b b=%0d exp a=%h s=%0b b=%0d",
                          out_addr, out_sub, out_bit, e.addr, e.sub, e.bofs));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung (act running, exp done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend = '{mb:24'h001000, ms:12'd20, sb:24'h080000, ss:12'd6,
             x0:10, x1:25, y0:5, y1:9, code:3};
    act = pend;
    repeat (3) @(negedge clk);
    rst = 0;
    #3;
    check(!out_valid && in_ready, "R1",
          $sformatf("act v=%0b r=%0b exp v=0 r=1", out_valid, in_ready));

    // window corners and neighbours at 8 bpp
    new_frame();
    send(10, 5, 0, "R2"); send(25, 9, 0, "R2"); send(25, 5, 0, "R2"); send(10, 9, 0, "R2");
    send(9, 5, 0, "R2");  send(26, 9, 0, "R2"); send(10, 4, 0, "R2"); send(25, 10, 0, "R2");
    send(0, 0, 0, "R3");  send(100, 30, 0, "R3"); send(17, 7, 0, "R4"); send(24, 8, 0, "R4");
    drain();

    // every depth code with random back-pressure
    rand_rdy = 1;
    for (int m = 0; m < 8; m++) begin
      pend.code = m;
      new_frame();
      for (int x = 0; x < 36; x++) send(x, 6, 0, (m == 4) ? "R6" : "R5");
      send(50, 2, 0, (m == 4) ? "R6" : "R5");
    end
    drain();

    // shadowing and the same-cycle reload collision
    rand_rdy = 0;
    pend.code = 3;
    new_frame();
    pend.x0 = 40; pend.x1 = 50; pend.sb = 24'h0C0000;
    send(12, 6, 0, "R7");
    drain();
    send(12, 6, 1, "R7");
    send(12, 6, 0, "R7");
    send(45, 6, 0, "R7");
    drain();

    // empty window: right edge left of left edge
    rand_rdy = 1;
    pend.x0 = 30; pend.x1 = 20;
    new_frame();
    for (int x = 15; x < 36; x++) send(x, 6, 0, "R10");
    pend.x0 = 10; pend.x1 = 25; pend.y0 = 9; pend.y1 = 5;
    new_frame();
    for (int y = 3; y < 12; y++) send(15, y, 0, "R10");
    drain();

    check(sb_q.size() == 0 && pushed == popped, "R9",
          $sformatf("act in=%0d out=%0d exp equal", pushed, popped));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule